// File: doc/BRIEF.md
# Virtual Program Counter Unit

This block keeps a 16-bit virtual program counter that follows how many bytes microcode has taken from an instruction buffer. It also keeps a saved copy of that counter. The live counter can be loaded from the result bus. It steps forward by one whenever the current microinstruction consumes a buffer byte. When the microinstruction performs an instruction dispatch, the counter value is captured into the saved copy.

A dispatch-trap input suppresses both the step and the capture. The saved copy and the live counter both answer reads on the register-file read address, at two fixed addresses. Two bits of the live counter are driven out as control outputs.

Everything runs on one clock. The capture into the saved copy takes the counter value from before the same edge's update. This models a copy that happens in the phase ahead of the counter update.

Top module: `vpcUnit`

## Requirements
- R1: While `rstN` is low, and on release, both the live counter and the saved copy are 0.
- R2: When `fieldX` equals 4'h7, the live counter takes `fBus` at the clock edge.
- R3: A byte is consumed when `fieldS[2]`=0 and `fieldZ[3:2]`=2'b00, or when `fieldY` is 4'h0 or 4'h1 and `fieldS[3]`=0. A consumed byte adds one to the live counter at the edge.
- R4: When a load (R2) and an increment (R3) are both requested, the load wins and the counter takes `fBus`.
- R5: Incrementing from 16'hFFFF gives 16'h0000.
- R6: While `dispTrap` is high, there is no increment and the saved copy holds. A load still takes effect.
- R7: When `fieldY` is 4'h0 or 4'h1, `fieldS[3]`=0 and `dispTrap` is low, the saved copy takes the live counter value held before that edge.
- R8: `readAddr`=14 returns the saved copy on `readData`, and `readAddr`=15 returns the live counter; `readHit` is high for these two addresses. Any other address gives `readData`=0 and `readHit` low.
- R9: `pcBit12` equals live counter bit 3 and `pcBit13` equals bit 2 (LSB is bit 0).
- R10: With no load, no increment and no save requested, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fBus | input | 16 | Result bus, the load source |
| fieldS | input | 4 | Microcode select field |
| fieldX | input | 4 | Microcode function field X |
| fieldY | input | 4 | Microcode function field Y |
| fieldZ | input | 4 | Microcode function field Z |
| dispTrap | input | 1 | Dispatch trap, blocks increment and save |
| readAddr | input | 4 | Register-file read address |
| readData | output | 16 | Pseudo-register read value |
| readHit | output | 1 | Address selects one of the two counters |
| pcBit12 | output | 1 | Exported live counter bit |
| pcBit13 | output | 1 | Exported live counter bit |

## Verification
A wrong live counter shows up on `pcBit12`/`pcBit13` in the same cycle only when one of the two exported bits differs. The full error appears on `readData` as soon as address 15 is read. A wrong saved copy stays hidden until address 14 is read, so the stimulus reads the addresses at random every cycle. A wrong decode of the consume or dispatch encodings gives a counter error one cycle after the edge, and it then persists until the next load.

// File: rtl/vpcPkg.sv
package vpcPkg;
  typedef struct packed {
    logic load;
    logic advance;
    logic save;
  } vpcStrobeT;
endpackage

// File: rtl/vpcCtrl.sv
module vpcCtrl
  import vpcPkg::*;
#(
  parameter int FIELD_W   = 4,
  parameter int LOAD_CODE = 7,
  parameter int DISP_LO   = 0,
  parameter int DISP_HI   = 1
) (
  input  logic [FIELD_W-1:0] fieldS,
  input  logic [FIELD_W-1:0] fieldX,
  input  logic [FIELD_W-1:0] fieldY,
  input  logic [FIELD_W-1:0] fieldZ,
  input  logic               dispTrap,
  output vpcStrobeT          strobe
);
  localparam int MSB = FIELD_W - 1;

  logic isDispatch;
  logic isByteTake;

  always_comb begin
    // dispatch encodings with the select MSB clear
    isDispatch = ((fieldY == FIELD_W'(DISP_LO)) || (fieldY == FIELD_W'(DISP_HI)))
                 && !fieldS[MSB];
    // buffer byte fetch encodings
    isByteTake = !fieldS[MSB-1] && (fieldZ[MSB:MSB-1] == 2'b00);
    strobe.load    = (fieldX == FIELD_W'(LOAD_CODE));
    strobe.advance = (isDispatch || isByteTake) && !dispTrap;
    strobe.save    = isDispatch && !dispTrap;
  end
endmodule

// File: rtl/vpcData.sv
module vpcData
  import vpcPkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int ADDR_W    = 4,
  parameter int SAVE_ADDR = 14,
  parameter int LIVE_ADDR = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  vpcStrobeT         strobe,
  input  logic [WIDTH-1:0]  fBus,
  input  logic [ADDR_W-1:0] readAddr,
  output logic [WIDTH-1:0]  readData,
  output logic              readHit,
  output logic [WIDTH-1:0]  vpcVal,
  output logic [WIDTH-1:0]  spcVal
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpcVal <= '0;
      spcVal <= '0;
    end else begin
      if (strobe.load)         vpcVal <= fBus;
      else if (strobe.advance) vpcVal <= vpcVal + ONE;
      if (strobe.save)         spcVal <= vpcVal;
    end
  end

  always_comb begin
    readData = '0;
    readHit  = 1'b0;
    if (readAddr == ADDR_W'(SAVE_ADDR)) begin
      readData = spcVal;
      readHit  = 1'b1;
    end else if (readAddr == ADDR_W'(LIVE_ADDR)) begin
      readData = vpcVal;
      readHit  = 1'b1;
    end
  end
endmodule

// File: rtl/vpcUnit.sv
module vpcUnit
  import vpcPkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int FIELD_W = 4,
  parameter int ADDR_W  = 4,
  parameter int EXP_HI  = 3,
  parameter int EXP_LO  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   fBus,
  input  logic [FIELD_W-1:0] fieldS,
  input  logic [FIELD_W-1:0] fieldX,
  input  logic [FIELD_W-1:0] fieldY,
  input  logic [FIELD_W-1:0] fieldZ,
  input  logic               dispTrap,
  input  logic [ADDR_W-1:0]  readAddr,
  output logic [WIDTH-1:0]   readData,
  output logic               readHit,
  output logic               pcBit12,
  output logic               pcBit13
);
  vpcStrobeT        strobe;
  logic [WIDTH-1:0] vpcVal;
  logic [WIDTH-1:0] spcVal;

  vpcCtrl #(.FIELD_W(FIELD_W)) uCtrl (
    .fieldS(fieldS), .fieldX(fieldX), .fieldY(fieldY), .fieldZ(fieldZ),
    .dispTrap(dispTrap), .strobe(strobe)
  );

  vpcData #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fBus(fBus),
    .readAddr(readAddr), .readData(readData), .readHit(readHit),
    .vpcVal(vpcVal), .spcVal(spcVal)
  );

  assign pcBit12 = vpcVal[EXP_HI];
  assign pcBit13 = vpcVal[EXP_LO];
endmodule

// File: rtl/vpcUnitChk.sv
module vpcUnitChk #(
  parameter int WIDTH   = 16,
  parameter int FIELD_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [WIDTH-1:0]   fBus,
  input logic [FIELD_W-1:0] fieldS,
  input logic [FIELD_W-1:0] fieldX,
  input logic [FIELD_W-1:0] fieldY,
  input logic [FIELD_W-1:0] fieldZ,
  input logic               dispTrap,
  input logic [WIDTH-1:0]   vpcVal,
  input logic [WIDTH-1:0]   spcVal
);
  logic dispReq;
  logic takeReq;
  logic loadReq;
  assign dispReq = (fieldY <= FIELD_W'(1)) && !fieldS[FIELD_W-1];
  assign takeReq = !fieldS[FIELD_W-2] && (fieldZ[FIELD_W-1:FIELD_W-2] == 2'b00);
  assign loadReq = (fieldX == FIELD_W'(7));

  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> vpcVal == $past(fBus));

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && !dispTrap && (dispReq || takeReq)) |=> vpcVal == $past(vpcVal) + WIDTH'(1));

  a_r6_trap_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dispTrap && !loadReq) |=> $stable(vpcVal) && $stable(spcVal));

  a_r7_save: assert property (@(posedge clk) disable iff (!rstN)
    (dispReq && !dispTrap) |=> spcVal == $past(vpcVal));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && !dispReq && !takeReq) |=> $stable(vpcVal) && $stable(spcVal));
endmodule

bind vpcUnit vpcUnitChk #(.WIDTH(WIDTH), .FIELD_W(FIELD_W)) uChk (
  .clk(clk), .rstN(rstN), .fBus(fBus), .fieldS(fieldS), .fieldX(fieldX),
  .fieldY(fieldY), .fieldZ(fieldZ), .dispTrap(dispTrap),
  .vpcVal(vpcVal), .spcVal(spcVal)
);

// File: tb/vpcUnit_test.sv
`timescale 1ns/1ps
module vpcUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] fBus = '0;
  logic [3:0]  fieldS = 4'hF, fieldX = '0, fieldY = 4'hF, fieldZ = 4'hF;
  logic        dispTrap = 1'b0;
  logic [3:0]  readAddr = '0;
  logic [15:0] readData;
  logic        readHit, pcBit12, pcBit13;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mV = '0, mS = '0;
  bit done = 0;

  always #4 clk = ~clk;

  vpcUnit uut (.clk(clk), .rstN(rstN), .fBus(fBus), .fieldS(fieldS),
    .fieldX(fieldX), .fieldY(fieldY), .fieldZ(fieldZ), .dispTrap(dispTrap),
    .readAddr(readAddr), .readData(readData), .readHit(readHit),
    .pcBit12(pcBit12), .pcBit13(pcBit13));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic isDisp(logic [3:0] s, logic [3:0] y);
    return (y == 4'h0 || y == 4'h1) && !s[3];
  endfunction

  function automatic logic isTake(logic [3:0] s, logic [3:0] z);
    return !s[2] && z[3:2] == 2'b00;
  endfunction

  // model: reads answer from the state held before the next edge
  function automatic logic [15:0] expRead(logic [3:0] a);
    if (a == 4'd14) return mS;
    if (a == 4'd15) return mV;
    return 16'h0;
  endfunction

  // drive one microinstruction at negedge, check outputs, then let the edge happen
  task automatic step(string req, logic [3:0] s, logic [3:0] x, logic [3:0] y,
                      logic [3:0] z, logic trap, logic [15:0] f, logic [3:0] a);
    logic [15:0] nV, nS;
    @(negedge clk);
    fieldS = s; fieldX = x; fieldY = y; fieldZ = z;
    dispTrap = trap; fBus = f; readAddr = a;
    #1;
    chk({req, "/R8 readData"}, 32'(readData), 32'(expRead(a)));
    chk("R8 readHit", 32'(readHit), 32'(a >= 4'd14));
    chk("R9 pcBit12", 32'(pcBit12), 32'(mV[3]));
    chk("R9 pcBit13", 32'(pcBit13), 32'(mV[2]));
    nV = mV; nS = mS;
    if (x == 4'h7) nV = f;                                   // R2, R4
    else if (!trap && (isDisp(s, y) || isTake(s, z))) nV = mV + 16'd1; // R3, R5, R6
    if (!trap && isDisp(s, y)) nS = mV;                      // R7
    @(posedge clk);
    mV = nV; mS = nS;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    readAddr = 4'd15; #1;
    chk("R1 vpc reset", 32'(readData), 32'h0);
    readAddr = 4'd14; #1;
    chk("R1 spc reset", 32'(readData), 32'h0);
    rstN = 1'b1;
    // idle: S MSBs set, Z upper bits set, X not load
    step("R10 idle", 4'hF, 4'h0, 4'h5, 4'hF, 0, 16'h1234, 4'd15);
    step("R10 idle", 4'hF, 4'h0, 4'h5, 4'hF, 0, 16'h1234, 4'd15);
    // R2 load
    step("R2 load", 4'hF, 4'h7, 4'h5, 4'hF, 0, 16'hFFFE, 4'd15);
    // R3 byte take via S/Z
    step("R3 take", 4'h0, 4'h0, 4'h5, 4'h3, 0, 16'h0, 4'd15);
    step("R3 after", 4'hF, 4'h0, 4'h5, 4'hF, 0, 16'h0, 4'd15);
    chk("R3 value FFFF", 32'(mV), 32'hFFFF);
    // R5 wrap + R7 save of pre-increment value
    step("R5 R7 dispatch", 4'h0, 4'h0, 4'h1, 4'hF, 0, 16'h0, 4'd15);
    step("R5 wrapped", 4'hF, 4'h0, 4'h5, 4'hF, 0, 16'h0, 4'd15);
    chk("R5 wrapped", 32'(readData), 32'h0000);
    step("R7 saved", 4'hF, 4'h0, 4'h5, 4'hF, 0, 16'h0, 4'd14);
    chk("R7 saved", 32'(readData), 32'hFFFF);
    // R6 trap blocks increment and save
    step("R6 trap", 4'h0, 4'h0, 4'h0, 4'h0, 1, 16'h0, 4'd15);
    step("R6 check", 4'hF, 4'h0, 4'h5, 4'hF, 0, 16'h0, 4'd14);
    chk("R6 spc held", 32'(readData), 32'hFFFF);
    // R4 load beats increment
    step("R4 both", 4'h0, 4'h7, 4'h0, 4'h0, 0, 16'h00AC, 4'd15);
    step("R4 check", 4'hF, 4'h0, 4'h5, 4'hF, 0, 16'h0, 4'd15);
    chk("R4 load wins", 32'(readData), 32'h00AC);
    chk("R9 bit12 of 00AC", 32'(pcBit12), 32'h1);
    // random
    for (int i = 0; i < 3000; i++) begin
      step("rand", 4'($urandom), ($urandom % 4 == 0) ? 4'h7 : 4'($urandom),
           4'($urandom % 4), 4'($urandom), ($urandom % 5 == 0), 16'($urandom),
           4'(($urandom % 2) ? 4'd14 + 4'($urandom % 2) : 4'($urandom)));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule